// File: doc/BRIEF.md
# Serial Flash Status Register Write Engine

This block is the slave-side status logic of a serial NOR flash. It watches chip select, a serial clock in either idle-low (mode 0) or idle-high (mode 3) form and a single data input, all oversampled through synchronizers in the system clock domain. It decodes an eight-bit opcode and then one or two data bytes. Two write-enable opcodes decide where a following status write lands. One sends it to the persistent copy through a timed busy cycle. The other sends it straight to the working copy.

The register is 16 bits wide and is read out as two bytes. Writes are filtered three ways: a mask of writable positions, a set of one-time-programmable bits that can only be set, and a length rule. The length rule accepts exactly one or two data bytes, and a one-byte write also clears three fixed high bits. A soft reset opcode throws away the working copy and reloads it from the persistent copy. While a persistent write is in progress only the two read opcodes are served.

Top module: `sr_write_engine`

## Requirements
- R1: After power-up reset both status bytes read back the persistent initial value (zero by default), with BUSY (byte 1 bit 0) and WEL (byte 1 bit 1) both 0.
- R2: Opcode 0x05 returns status byte 1 as {image[7:2], WEL, BUSY} and opcode 0x35 returns status byte 2 as {0, image[14:8]}. Each byte leaves MSB first, one bit per falling serial-clock edge, and repeats for as long as chip select stays low.
- R3: Opcode 0x06 sets WEL and disarms the volatile path. Opcode 0x50 arms the volatile path and clears WEL. A volatile write uses up the arming.
- R4: A write changes only image bits 14..2. Byte 1 bits 1..0 and byte 2 bit 7 are never set by write data.
- R5: A status write (0x01) sent with neither WEL set nor the volatile path armed changes nothing.
- R6: In a two-byte write the first data byte goes to status byte 1 and the second to status byte 2.
- R7: A one-byte write loads status byte 1 and clears CMP (byte 2 bit 6), QE (byte 2 bit 1) and SRP1 (byte 2 bit 0), subject to R9.
- R8: A status write whose chip select rises after any count other than 8 or 16 data bits is dropped, and WEL is left as it was.
- R9: The bits at byte 2 positions 5..2 (lock bits) and position 0 (SRP1) never go from 1 to 0 through a write, on either path.
- R10: A persistent write holds BUSY at 1 for BUSY_CYCLES system clocks. At the end it updates both copies and clears WEL. A volatile write takes effect at once and never raises BUSY.
- R11: While BUSY is 1, opcodes 0x06, 0x50, 0x01 and 0x99 are ignored. Reads still work.
- R12: Opcode 0x99 reloads the working copy from the persistent copy, clears WEL and disarms the volatile path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low power-up reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 or mode 3 |
| mosi | input | 1 | Serial data in, sampled on rising sck |
| miso | output | 1 | Serial data out, changed on falling sck |

## Verification
Every serial pin passes through two synchronizer stages and one edge register, so a rising or falling sck takes effect about four system clocks after the pin moves. A read bit is driven about four clocks after its falling edge. The bench uses eight system clocks per sck half period and samples miso just before each rising edge, which leaves a margin of several clocks. Control opcodes and volatile writes act on the chip-select rise, and the bench allows four half periods of idle time before the next command. A persistent write is checked twice: once while it runs, by reading BUSY=1 and the old image, and again after waiting more than BUSY_CYCLES clocks, when the new image must be present and WEL must be clear.

// File: rtl/sr_pkg.sv
package sr_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRVOL = 8'h50;
  localparam logic [7:0] OP_RD1   = 8'h05;
  localparam logic [7:0] OP_RD2   = 8'h35;
  localparam logic [7:0] OP_RST   = 8'h99;

  // writable image bits 14..2
  localparam logic [15:0] WR_MASK   = 16'h7FFC;
  // lock bits 13..10 and SRP1 bit 8: set-only
  localparam logic [15:0] OTP_MASK  = 16'h3D00;
  // CMP bit 14, QE bit 9, SRP1 bit 8: cleared by one-byte write
  localparam logic [15:0] SHORT_CLR = 16'h4300;

  function automatic logic [15:0] sr_merge(input logic [15:0] cur,
                                           input logic [15:0] wdat,
                                           input logic        short_wr);
    logic [15:0] d;
    logic [15:0] nxt;
    d   = short_wr ? {cur[15:8] & ~SHORT_CLR[15:8], wdat[7:0]} : wdat;
    nxt = (cur & ~WR_MASK) | (d & WR_MASK);
    return nxt | (cur & OTP_MASK);
  endfunction

  function automatic logic [7:0] status_byte(input logic [15:0] img,
                                             input logic wel,
                                             input logic busy,
                                             input logic hi);
    return hi ? {1'b0, img[14:8]} : {img[7:2], wel, busy};
  endfunction
endpackage

// File: rtl/spi_front.sv
module spi_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        mosi,
  output logic        cs_low,
  output logic        cs_rise,
  output logic        sck_fall,
  output logic        op_stb,
  output logic [7:0]  opcode,
  output logic [15:0] data_sh,
  output logic [4:0]  bit_cnt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] cs_p, sck_p, mo_p;
  logic cs_q, sck_q;
  logic cs_s, sck_s, mo_s;
  logic sck_rise, cs_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_p  <= '1;
      sck_p <= '0;
      mo_p  <= '0;
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_p  <= {cs_p[LAST-1:0], cs_n};
      sck_p <= {sck_p[LAST-1:0], sck};
      mo_p  <= {mo_p[LAST-1:0], mosi};
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_s     = cs_p[LAST];
  assign sck_s    = sck_p[LAST];
  assign mo_s     = mo_p[LAST];
  assign cs_low   = ~cs_s;
  assign cs_rise  = cs_s & ~cs_q;
  assign cs_fall  = ~cs_s & cs_q;
  assign sck_rise = cs_low & sck_s & ~sck_q;
  assign sck_fall = cs_low & ~sck_s & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      opcode  <= '0;
      data_sh <= '0;
      op_stb  <= 1'b0;
    end else begin
      op_stb <= sck_rise && (bit_cnt == 5'd7);
      if (cs_fall) begin
        bit_cnt <= '0;
      end else if (sck_rise) begin
        if (bit_cnt != 5'd31) bit_cnt <= bit_cnt + 5'd1;
        if (bit_cnt < 5'd8) opcode <= {opcode[6:0], mo_s};
        else                data_sh <= {data_sh[14:0], mo_s};
      end
    end
  end
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        cnt  <= CW'(CYCLES);
        busy <= 1'b1;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R10: busy never runs with an empty count
  p_busy_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt != '0));
endmodule

// File: rtl/sr_regs.sv
module sr_regs #(
  parameter logic [15:0] NV_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_wel,
  input  logic        set_varm,
  input  logic        soft_rst,
  input  logic        vol_wr,
  input  logic        nv_start,
  input  logic        nv_done,
  input  logic [15:0] wdata,
  input  logic        short_wr,
  output logic [15:0] vol_img,
  output logic [15:0] nv_img,
  output logic        wel,
  output logic        varm
);
  import sr_pkg::*;

  logic [15:0] pend;
  logic        pend_short;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_img    <= NV_INIT;
      nv_img     <= NV_INIT;
      wel        <= 1'b0;
      varm       <= 1'b0;
      pend       <= '0;
      pend_short <= 1'b0;
    end else begin
      if (soft_rst) begin
        vol_img <= nv_img;
        wel     <= 1'b0;
        varm    <= 1'b0;
      end
      if (set_wel) begin
        wel  <= 1'b1;
        varm <= 1'b0;
      end
      if (set_varm) begin
        varm <= 1'b1;
        wel  <= 1'b0;
      end
      if (vol_wr) begin
        vol_img <= sr_merge(vol_img, wdata, short_wr);
        varm    <= 1'b0;
      end
      if (nv_start) begin
        pend       <= wdata;
        pend_short <= short_wr;
      end
      if (nv_done) begin
        nv_img  <= sr_merge(nv_img, pend, pend_short);
        vol_img <= sr_merge(vol_img, pend, pend_short);
        wel     <= 1'b0;
      end
    end
  end

  // R3: the two enables never coexist
  p_enable_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wel && varm));
  // R9: persistent lock bits only ever gain ones
  p_otp_nv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(nv_img) & OTP_MASK & ~nv_img) == 16'h0000));
  // R9: working lock bits only gain ones, except on reload
  p_otp_vol_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> (($past(vol_img) & OTP_MASK & ~vol_img) == 16'h0000));
endmodule

// File: rtl/sr_write_engine.sv
module sr_write_engine #(
  parameter int          BUSY_CYCLES = 1000,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] NV_INIT     = 16'h0000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  import sr_pkg::*;

  logic        cs_low, cs_rise, sck_fall, op_stb;
  logic [7:0]  opcode;
  logic [15:0] data_sh;
  logic [4:0]  bit_cnt;
  logic        busy, nv_done, wel, varm;
  logic [15:0] vol_img, nv_img, wdata;

  spi_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .cs_low(cs_low), .cs_rise(cs_rise), .sck_fall(sck_fall),
    .op_stb(op_stb), .opcode(opcode), .data_sh(data_sh), .bit_cnt(bit_cnt)
  );

  // command events, all taken at the chip-select rise
  logic at8, len_ok, short_wr, engaged, is_wr;
  logic set_wel, set_varm, soft_rst, wr_ok, nv_start, vol_wr, wr_bad;

  assign at8      = (bit_cnt == 5'd8);
  assign short_wr = (bit_cnt == 5'd16);
  assign len_ok   = short_wr || (bit_cnt == 5'd24);
  assign engaged  = busy | nv_done;
  assign is_wr    = cs_rise && (opcode == OP_WRSR) && (bit_cnt >= 5'd8);
  assign set_wel  = cs_rise && at8 && (opcode == OP_WREN)  && !engaged;
  assign set_varm = cs_rise && at8 && (opcode == OP_WRVOL) && !engaged;
  assign soft_rst = cs_rise && at8 && (opcode == OP_RST)   && !engaged;
  assign wr_ok    = is_wr && len_ok && !engaged;
  assign nv_start = wr_ok && wel;
  assign vol_wr   = wr_ok && !wel && varm;
  assign wr_bad   = is_wr && !len_ok;
  assign wdata    = short_wr ? {8'h00, data_sh[7:0]} : {data_sh[7:0], data_sh[15:8]};

  sr_regs #(.NV_INIT(NV_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .set_wel(set_wel), .set_varm(set_varm),
    .soft_rst(soft_rst), .vol_wr(vol_wr), .nv_start(nv_start), .nv_done(nv_done),
    .wdata(wdata), .short_wr(short_wr), .vol_img(vol_img), .nv_img(nv_img),
    .wel(wel), .varm(varm)
  );

  busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(busy), .done(nv_done)
  );

  // read-out path: live byte, one bit per falling edge, wraps every 8
  logic       rd_act, rd_hi;
  logic [2:0] rd_idx;
  logic [7:0] rd_byte;

  assign rd_byte = status_byte(vol_img, wel, busy, rd_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act <= 1'b0;
      rd_hi  <= 1'b0;
      rd_idx <= '0;
      miso   <= 1'b0;
    end else if (!cs_low) begin
      rd_act <= 1'b0;
      miso   <= 1'b0;
    end else if (op_stb) begin
      rd_act <= (opcode == OP_RD1) || (opcode == OP_RD2);
      rd_hi  <= (opcode == OP_RD2);
      rd_idx <= '0;
    end else if (sck_fall && rd_act) begin
      miso   <= rd_byte[3'd7 - rd_idx];
      rd_idx <= rd_idx + 3'd1;
    end
  end

  // R11: a persistent cycle never starts on top of a running one
  p_start_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    nv_start |-> !busy);
  // R10: WEL is clear once a persistent cycle ends
  p_wel_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nv_done |=> !wel);
  // R8: a badly sized write leaves the working copy alone
  p_abort_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bad && !nv_done) |=> $stable(vol_img));
  // R2: nothing is shifted out while deselected
  p_miso_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> !miso);
endmodule

// File: tb/sr_write_engine_bench.sv
`timescale 1ns/1ps
module sr_write_engine_bench;
  localparam int HALF = 8;
  localparam int BUSYC = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic miso;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sr_write_engine #(.BUSY_CYCLES(BUSYC)) u_sr_write_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic tick(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic [23:0] got, input logic [23:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // n bits MSB first from tx; rx collects miso just before each rising edge
  task automatic xfer(input logic [31:0] tx, input int n, input bit m3,
                      output logic [31:0] rx);
    rx = '0;
    sck = m3;
    tick(HALF);
    cs_n = 1'b0;
    tick(HALF);
    for (int i = 0; i < n; i++) begin
      sck  = 1'b0;
      mosi = tx[31-i];
      tick(HALF);
      rx  = {rx[30:0], miso};
      sck = 1'b1;
      tick(HALF);
    end
    if (!m3) sck = 1'b0;
    tick(HALF);
    cs_n = 1'b1;
    tick(4*HALF);
    sck = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op, input bit m3 = 1'b0);
    logic [31:0] r;
    xfer({op, 24'h0}, 8, m3, r);
  endtask

  task automatic wr16(input logic [7:0] b1, input logic [7:0] b2);
    logic [31:0] r;
    xfer({8'h01, b1, b2, 8'h00}, 24, 1'b0, r);
  endtask

  task automatic wr8(input logic [7:0] b1);
    logic [31:0] r;
    xfer({8'h01, b1, 16'h0}, 16, 1'b0, r);
  endtask

  task automatic rd(input logic [7:0] op, input bit m3, output logic [7:0] v);
    logic [31:0] r;
    xfer({op, 24'h0}, 16, m3, r);
    v = r[7:0];
  endtask

  task automatic chk_sr(input logic [7:0] e1, input logic [7:0] e2, input string tag);
    logic [7:0] v;
    rd(8'h05, 1'b0, v);
    chk({16'h0, v}, {16'h0, e1}, {tag, " byte1"});
    rd(8'h35, 1'b0, v);
    chk({16'h0, v}, {16'h0, e2}, {tag, " byte2"});
  endtask

  task automatic t_reset();
    chk_sr(8'h00, 8'h00, "R1 reset state");
  endtask

  task automatic t_no_enable();
    wr16(8'hAA, 8'h02);
    chk_sr(8'h00, 8'h00, "R5 write without enable");
  endtask

  task automatic t_nv_write();
    logic [7:0] v;
    cmd(8'h06);
    rd(8'h05, 1'b0, v);
    chk({16'h0, v}, 24'h02, "R3 WEL set by 0x06");
    wr16(8'h1C, 8'h02);
    rd(8'h05, 1'b0, v);
    chk({16'h0, v}, 24'h03, "R10 busy and old image during cycle");
    cmd(8'h50);
    cmd(8'h99);
    tick(BUSYC + 200);
    chk_sr(8'h1C, 8'h02, "R6 R10 persistent write result");
    wr16(8'h00, 8'h00);
    rd(8'h05, 1'b0, v);
    chk({16'h0, v}, 24'h1C, "R11 enable sent while busy ignored");
  endtask

  task automatic t_repeat_read();
    logic [31:0] r;
    xfer({8'h35, 24'h0}, 32, 1'b0, r);
    chk(r[23:0], 24'h020202, "R2 byte repeats while selected");
  endtask

  task automatic t_volatile();
    logic [7:0] v;
    cmd(8'h50);
    rd(8'h05, 1'b0, v);
    chk({16'h0, v}, 24'h1C, "R3 0x50 leaves WEL clear");
    wr16(8'h24, 8'h40);
    chk_sr(8'h24, 8'h40, "R10 volatile write immediate, no busy");
    wr16(8'h00, 8'h00);
    rd(8'h05, 1'b0, v);
    chk({16'h0, v}, 24'h24, "R3 volatile arming used up");
  endtask

  task automatic t_soft_reset();
    logic [7:0] v;
    cmd(8'h99, 1'b1);
    rd(8'h05, 1'b1, v);
    chk({16'h0, v}, 24'h1C, "R12 reload byte1 (mode 3)");
    rd(8'h35, 1'b1, v);
    chk({16'h0, v}, 24'h02, "R12 reload byte2 (mode 3)");
  endtask

  task automatic t_short();
    cmd(8'h06);
    wr16(8'h1C, 8'h43);
    tick(BUSYC + 200);
    chk_sr(8'h1C, 8'h43, "R6 CMP QE SRP1 set");
    cmd(8'h06);
    wr8(8'h80);
    tick(BUSYC + 200);
    chk_sr(8'h80, 8'h01, "R7 R9 one-byte write clears CMP QE, SRP1 kept");
  endtask

  task automatic t_abort();
    logic [31:0] r;
    cmd(8'h06);
    xfer({8'h01, 8'hFF, 8'hF0, 8'h00}, 20, 1'b0, r);
    tick(BUSYC + 200);
    chk_sr(8'h82, 8'h01, "R8 twelve-bit write dropped");
    cmd(8'h99);
    chk_sr(8'h80, 8'h01, "R12 soft reset clears WEL");
  endtask

  task automatic t_vol_otp();
    cmd(8'h50);
    wr16(8'hFF, 8'hFF);
    chk_sr(8'hFC, 8'h7F, "R4 volatile write mask");
    cmd(8'h50);
    wr16(8'h00, 8'h00);
    chk_sr(8'h00, 8'h3D, "R9 volatile lock bits stick");
    cmd(8'h99);
    chk_sr(8'h80, 8'h01, "R12 volatile locks discarded");
  endtask

  task automatic t_nv_otp();
    cmd(8'h06);
    wr16(8'hFF, 8'hFF);
    tick(BUSYC + 200);
    chk_sr(8'hFC, 8'h7F, "R4 persistent write mask");
    cmd(8'h06);
    wr16(8'h00, 8'h00);
    tick(BUSYC + 200);
    chk_sr(8'h00, 8'h3D, "R9 persistent lock bits stick");
  endtask

  initial begin
    tick(10);
    rst_n = 1'b1;
    tick(10);
    t_reset();
    t_no_enable();
    t_nv_write();
    t_repeat_read();
    t_volatile();
    t_soft_reset();
    t_short();
    t_abort();
    t_vol_otp();
    t_nv_otp();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule